// File: doc/BRIEF.md
# Time-Triggered Ingress Window Guard

This block watches the receive byte stream at one ingress port of a switch in a time-triggered Ethernet network. It reads the six destination address bytes of each frame. From them it decides whether the frame belongs to scheduled critical traffic or to ordinary best-effort traffic.

For a critical frame, the last two address bytes name a virtual link. That link is looked up in a small table of acceptance windows. The local cycle-relative time, captured when the frame starts, must fall inside the matching window, or the frame is dropped. This policing keeps a faulty sender from disturbing the schedule. Frames that carry no critical marker are passed to the best-effort path unchanged.

The verdict is a one-cycle strobe with pass, drop, class and runt flags. The flags stay held until the next frame begins. Two saturating counters record window violations and unknown-link drops.

Top module: `tt_ingress_guard`

## Requirements
- R1: Destination bytes 0..3 (arrival order, byte 0 most significant) form a 32-bit marker. A frame is critical (dec_class=1) exactly when the marker equals `cluster_marker`; a difference in any one of the four bytes makes it non-critical.
- R2: A non-critical frame gives dec_pass=1, dec_drop=0 and dec_class=0, whatever its link or arrival time. Neither counter changes.
- R3: Destination bytes 4..5 (byte 4 most significant) form the 16-bit link identifier. It is compared in parallel against all valid table entries. When several valid entries match, the lowest index decides.
- R4: A critical frame whose link matches no valid entry gives dec_drop=1 and dec_class=1, and drop_unknown_cnt increases by one.
- R5: The arrival time is the value of `now_ticks` on the start-of-frame byte. A critical frame with a matching entry passes when start <= time <= end (unsigned, inclusive). Otherwise it is dropped and drop_window_cnt increases by one. An entry with start > end accepts no time.
- R6: dec_valid is high for exactly one cycle. For a frame of six or more bytes, that is the cycle after the clock edge that accepts destination byte 5. The flags are held until the clock edge that accepts the next start-of-frame byte, which clears dec_pass, dec_drop, dec_class and dec_runt to 0.
- R7: A frame whose end strobe comes on destination byte 0..4 gives dec_valid the cycle after that byte, with dec_drop=1, dec_runt=1, dec_pass=0 and dec_class=0. No counter changes.
- R8: Each counter stops at 2^CNT_W-1 and never decreases outside reset.
- R9: After reset all outputs are 0 and the table holds no valid entry, so any critical frame is an unknown-link drop.
- R10: A table write (cfg_we high) to entry cfg_idx sets its valid bit, link, start and end. It affects lookups from the next cycle on. A write at the same edge as destination byte 5 is not seen by that frame.
- R11: Cycles with rx_valid low inside a frame are ignored. Bytes after the sixth destination byte do not alter the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe of the receive stream |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Received byte |
| now_ticks | input | 32 | Cycle-relative local time |
| cluster_marker | input | 32 | Configured critical-traffic marker |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 4 | Table entry to write |
| cfg_vld | input | 1 | Valid bit to write |
| cfg_link | input | 16 | Link identifier to write |
| cfg_start | input | 32 | Window start to write |
| cfg_end | input | 32 | Window end to write |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_pass | output | 1 | Frame forwarded |
| dec_drop | output | 1 | Frame discarded |
| dec_class | output | 1 | 1 critical, 0 best effort |
| dec_runt | output | 1 | Frame ended inside the address |
| drop_window_cnt | output | 16 | Saturating count of window drops |
| drop_unknown_cnt | output | 16 | Saturating count of unknown-link drops |

## Verification
A table write and a header lookup can fall in the same cycle: the write edge coincides with the edge that accepts destination byte 5. The bench provokes this by raising cfg_we on the exact cycle it drives the last address byte. It does so both to invalidate the entry in use and to install an entry that was missing. It judges the result from two verdicts. The coinciding frame must follow the table contents before the write, and the next identical frame must follow the contents after it.

// File: rtl/tt_guard_pkg.sv
package tt_guard_pkg;

  localparam int CTR_WIN = 0;
  localparam int CTR_UNK = 1;
  localparam int NUM_CTR = 2;

  typedef enum logic [1:0] {
    VERD_FWD_BE  = 2'd0,
    VERD_FWD_TT  = 2'd1,
    VERD_DROP_WIN = 2'd2,
    VERD_DROP_UNK = 2'd3
  } verdict_e;

endpackage

// File: rtl/tt_hdr_parse.sv
module tt_hdr_parse #(
  parameter int MARK_W = 32,
  parameter int LINK_W = 16,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [TIME_W-1:0] now_ticks,
  output logic              hdr_done,
  output logic              hdr_runt,
  output logic              hdr_sof,
  output logic [MARK_W-1:0] hdr_marker,
  output logic [LINK_W-1:0] hdr_link,
  output logic [TIME_W-1:0] arr_time
);

  localparam int HDR_BYTES = (MARK_W + LINK_W) / 8;
  localparam int SR_W      = MARK_W + LINK_W - 8;
  localparam int IDX_W     = $clog2(HDR_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(HDR_BYTES);

  logic [IDX_W-1:0]  idx_q;
  logic              active_q;
  logic [SR_W-1:0]   hdr_sr;
  logic [TIME_W-1:0] ts_q;

  // byte counter, header shift register and arrival timestamp
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      active_q <= 1'b0;
      hdr_sr   <= '0;
      ts_q     <= '0;
    end else if (rx_valid) begin
      if (rx_sof) begin
        ts_q     <= now_ticks;
        hdr_sr   <= {{(SR_W-8){1'b0}}, rx_data};
        idx_q    <= IDX_W'(1);
        active_q <= !rx_eof;
      end else if (active_q) begin
        hdr_sr <= {hdr_sr[SR_W-9:0], rx_data};
        idx_q  <= idx_q + IDX_W'(1);
        if (rx_eof || idx_q == LAST_IDX) active_q <= 1'b0;
      end
    end
  end

  assign hdr_sof  = rx_valid && rx_sof;
  assign hdr_done = rx_valid && !rx_sof && active_q && (idx_q == LAST_IDX);
  assign hdr_runt = rx_valid && rx_eof &&
                    (rx_sof || (active_q && (idx_q < LAST_IDX)));
  assign {hdr_marker, hdr_link} = {hdr_sr, rx_data};
  assign arr_time = ts_q;

  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= DONE_IDX);

  // R11
  hdr_close_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_done |=> !active_q);

  // R7
  runt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hdr_done && hdr_runt));

endmodule

// File: rtl/tt_vl_table.sv
module tt_vl_table #(
  parameter int ENTRIES = 16,
  parameter int LINK_W  = 16,
  parameter int TIME_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_vld,
  input  logic [LINK_W-1:0] cfg_link,
  input  logic [TIME_W-1:0] cfg_start,
  input  logic [TIME_W-1:0] cfg_end,
  input  logic [LINK_W-1:0] q_link,
  input  logic [TIME_W-1:0] q_time,
  output logic              q_found,
  output logic              q_in_win
);

  logic [ENTRIES-1:0] vld_q;
  logic [LINK_W-1:0]  link_q  [ENTRIES];
  logic [TIME_W-1:0]  start_q [ENTRIES];
  logic [TIME_W-1:0]  end_q   [ENTRIES];
  logic [ENTRIES-1:0] hit;
  logic [ENTRIES-1:0] inwin;

  always_ff @(posedge clk) begin
    if (rst)         vld_q <= '0;
    else if (cfg_we) vld_q[cfg_idx] <= cfg_vld;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      link_q[cfg_idx]  <= cfg_link;
      start_q[cfg_idx] <= cfg_start;
      end_q[cfg_idx]   <= cfg_end;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit[e]   = vld_q[e] && (link_q[e] == q_link);
    assign inwin[e] = (q_time >= start_q[e]) && (q_time <= end_q[e]);
  end

  // lowest matching index wins
  always_comb begin
    q_found  = 1'b0;
    q_in_win = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit[e]) begin
        q_found  = 1'b1;
        q_in_win = inwin[e];
      end
    end
  end

  // R10
  cfg_apply_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (vld_q[$past(cfg_idx)] == $past(cfg_vld)));

  // R10
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(vld_q));

endmodule

// File: rtl/tt_sat_ctr.sv
module tt_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (inc && cnt != MAX)  cnt <= cnt + W'(1);
  end

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAX) |=> (cnt == MAX));

  // R8
  ctr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> $past(inc));

endmodule

// File: rtl/tt_ingress_guard.sv
module tt_ingress_guard
  import tt_guard_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int MARK_W  = 32,
  parameter int LINK_W  = 16,
  parameter int TIME_W  = 32,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [TIME_W-1:0] now_ticks,
  input  logic [MARK_W-1:0] cluster_marker,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_vld,
  input  logic [LINK_W-1:0] cfg_link,
  input  logic [TIME_W-1:0] cfg_start,
  input  logic [TIME_W-1:0] cfg_end,
  output logic              dec_valid,
  output logic              dec_pass,
  output logic              dec_drop,
  output logic              dec_class,
  output logic              dec_runt,
  output logic [CNT_W-1:0]  drop_window_cnt,
  output logic [CNT_W-1:0]  drop_unknown_cnt
);

  logic              hdr_done, hdr_runt, hdr_sof;
  logic [MARK_W-1:0] hdr_marker;
  logic [LINK_W-1:0] hdr_link;
  logic [TIME_W-1:0] arr_time;
  logic              q_found, q_in_win;
  verdict_e          verdict;
  logic [NUM_CTR-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_val [NUM_CTR];

  tt_hdr_parse #(.MARK_W(MARK_W), .LINK_W(LINK_W), .TIME_W(TIME_W)) u_parse (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .now_ticks(now_ticks), .hdr_done(hdr_done),
    .hdr_runt(hdr_runt), .hdr_sof(hdr_sof), .hdr_marker(hdr_marker),
    .hdr_link(hdr_link), .arr_time(arr_time)
  );

  tt_vl_table #(.ENTRIES(ENTRIES), .LINK_W(LINK_W), .TIME_W(TIME_W)) u_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vld(cfg_vld),
    .cfg_link(cfg_link), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .q_link(hdr_link), .q_time(arr_time), .q_found(q_found), .q_in_win(q_in_win)
  );

  always_comb begin
    if (hdr_marker != cluster_marker) verdict = VERD_FWD_BE;
    else if (!q_found)                verdict = VERD_DROP_UNK;
    else if (!q_in_win)               verdict = VERD_DROP_WIN;
    else                              verdict = VERD_FWD_TT;
  end

  always_comb begin
    cnt_inc          = '0;
    cnt_inc[CTR_WIN] = hdr_done && (verdict == VERD_DROP_WIN);
    cnt_inc[CTR_UNK] = hdr_done && (verdict == VERD_DROP_UNK);
  end

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    tt_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .inc(cnt_inc[c]), .cnt(cnt_val[c])
    );
  end

  assign drop_window_cnt  = cnt_val[CTR_WIN];
  assign drop_unknown_cnt = cnt_val[CTR_UNK];

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_pass  <= 1'b0;
      dec_drop  <= 1'b0;
      dec_class <= 1'b0;
      dec_runt  <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (hdr_runt) begin
        dec_valid <= 1'b1;
        dec_pass  <= 1'b0;
        dec_drop  <= 1'b1;
        dec_class <= 1'b0;
        dec_runt  <= 1'b1;
      end else if (hdr_done) begin
        dec_valid <= 1'b1;
        dec_pass  <= (verdict == VERD_FWD_BE) || (verdict == VERD_FWD_TT);
        dec_drop  <= (verdict == VERD_DROP_WIN) || (verdict == VERD_DROP_UNK);
        dec_class <= (verdict != VERD_FWD_BE);
        dec_runt  <= 1'b0;
      end else if (hdr_sof) begin
        dec_pass  <= 1'b0;
        dec_drop  <= 1'b0;
        dec_class <= 1'b0;
        dec_runt  <= 1'b0;
      end
    end
  end

  // R6
  pass_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_pass ^ dec_drop));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dec_valid && !$past(rx_valid && rx_sof)) |->
      ($stable(dec_pass) && $stable(dec_drop) && $stable(dec_class)));

  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(rx_valid));

  // R7
  runt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    dec_runt |-> (dec_drop && !dec_pass && !dec_class));

  // R8
  ctr_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(cnt_inc) <= 1);

endmodule

// File: tb/tb_tt_ingress_guard.sv
`timescale 1ns/1ps
module tb_tt_ingress_guard;

  localparam int CW = 4;
  localparam logic [31:0] CM = 32'h0A1B2C3D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0]  rx_data = 0;
  logic [31:0] now_ticks = 0;
  logic        cfg_we = 0, cfg_vld = 0;
  logic [3:0]  cfg_idx = 0;
  logic [15:0] cfg_link = 0;
  logic [31:0] cfg_start = 0, cfg_end = 0;
  logic        dec_valid, dec_pass, dec_drop, dec_class, dec_runt;
  logic [CW-1:0] drop_window_cnt, drop_unknown_cnt;

  int total = 0, bad = 0;
  int exp_win = 0, exp_unk = 0;
  bit finished = 0;

  bit          cc_pend = 0, cc_vld = 0;
  logic [3:0]  cc_idx = 0;
  logic [15:0] cc_link = 0;
  logic [31:0] cc_lo = 0, cc_hi = 0;

  always #10 clk = ~clk;

  tt_ingress_guard #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .now_ticks(now_ticks), .cluster_marker(CM),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vld(cfg_vld), .cfg_link(cfg_link),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .dec_valid(dec_valid),
    .dec_pass(dec_pass), .dec_drop(dec_drop), .dec_class(dec_class),
    .dec_runt(dec_runt), .drop_window_cnt(drop_window_cnt),
    .drop_unknown_cnt(drop_unknown_cnt)
  );

  function automatic logic [31:0] win_lo(int e);
    return 32'(e * 100);
  endfunction
  function automatic logic [31:0] win_hi(int e);
    return (e == 15) ? 32'(e * 100 - 10) : 32'(e * 100 + 20);
  endfunction
  function automatic logic [15:0] link_of(int e);
    return 16'(16'h0100 + e * 3);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // order: valid, pass, drop, class, runt
  task automatic check_dec(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {dec_valid, dec_pass, dec_drop, dec_class, dec_runt};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: verdict actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_cnt(string req);
    total++;
    if (drop_window_cnt !== CW'(exp_win) || drop_unknown_cnt !== CW'(exp_unk)) begin
      bad++;
      $display("FAIL %s: counters actual=%0d/%0d expected=%0d/%0d", req,
               drop_window_cnt, drop_unknown_cnt, exp_win, exp_unk);
    end
  endtask

  task automatic bump_win();
    if (exp_win < (1 << CW) - 1) exp_win++;
  endtask
  task automatic bump_unk();
    if (exp_unk < (1 << CW) - 1) exp_unk++;
  endtask

  task automatic cfg_write(int e, bit v, logic [15:0] lk, logic [31:0] lo, logic [31:0] hi);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(e); cfg_vld = v; cfg_link = lk; cfg_start = lo; cfg_end = hi;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // sends nb bytes; gap inserts one idle cycle after each non-final byte
  task automatic send_frame(logic [31:0] mk, logic [15:0] lk, int nb, logic [31:0] ts, bit gap);
    logic [7:0] hb [6];
    hb[0] = mk[31:24]; hb[1] = mk[23:16]; hb[2] = mk[15:8]; hb[3] = mk[7:0];
    hb[4] = lk[15:8];  hb[5] = lk[7:0];
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      cfg_we    = 0;
      rx_valid  = 1;
      rx_sof    = (i == 0);
      rx_eof    = (i == nb - 1);
      rx_data   = (i < 6) ? hb[i] : 8'hA5;
      now_ticks = (i == 0) ? ts : ts + 32'd777;
      if (i == 5 && cc_pend) begin
        cfg_we = 1; cfg_idx = cc_idx; cfg_vld = cc_vld; cfg_link = cc_link;
        cfg_start = cc_lo; cfg_end = cc_hi; cc_pend = 0;
      end
      if (gap && i < nb - 1) begin
        @(negedge clk);
        cfg_we = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 8'h5A;
      end
    end
    @(negedge clk);
    cfg_we = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] t;
    bit ok;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check_dec("R9 reset outputs", 5'b00000);
    check_cnt("R9 reset counters");

    // R9 empty table: critical frame is an unknown link
    send_frame(CM, link_of(0), 6, 32'd5, 0);
    check_dec("R9 R4 empty table drop", 5'b10110);
    bump_unk();
    check_cnt("R4 unknown count");

    for (int e = 0; e < 16; e++) cfg_write(e, 1, link_of(e), win_lo(e), win_hi(e));

    // R5 window sweep at both edges of every entry
    for (int e = 0; e < 16; e++) begin
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: t = win_lo(e) - 32'd1;
          1: t = win_lo(e);
          2: t = win_hi(e);
          default: t = win_hi(e) + 32'd1;
        endcase
        ok = (t >= win_lo(e)) && (t <= win_hi(e));
        send_frame(CM, link_of(e), 6, t, k == 3);  // R11 gaps on k==3
        if (ok) check_dec("R5 inside window pass", 5'b11010);
        else begin
          check_dec("R5 outside window drop", 5'b10110);
          bump_win();
        end
        check_cnt("R5 R8 window counter");
        if (k == 0) begin
          @(negedge clk);
          check_dec("R6 strobe lasts one cycle", ok ? 5'b01010 : 5'b00110);
        end
      end
    end

    // R4 unconfigured links
    for (int j = 0; j < 4; j++) begin
      send_frame(CM, 16'(16'h0101 + j * 3), 6, 32'd10, 0);
      check_dec("R4 unknown link drop", 5'b10110);
      bump_unk();
      check_cnt("R4 R8 unknown counter");
    end

    // R1 R2 one differing marker byte makes it best effort
    for (int j = 0; j < 4; j++) begin
      send_frame(CM ^ (32'h80 << (8 * j)), link_of(0), 6, 32'd9999, 0);
      check_dec("R1 R2 non-critical pass", 5'b11000);
      check_cnt("R2 counters unchanged");
    end

    // R6 R11 long frame: verdict held, trailing bytes ignored
    send_frame(CM, link_of(2), 9, 32'd205, 0);
    check_dec("R11 R6 held after extra bytes", 5'b01010);
    repeat (3) @(negedge clk);
    check_dec("R6 held while idle", 5'b01010);
    rx_valid = 1; rx_sof = 1; rx_eof = 0; rx_data = 8'h0A; now_ticks = 0;
    @(negedge clk);
    rx_valid = 0; rx_sof = 0;
    check_dec("R6 cleared by start of frame", 5'b00000);

    // R7 runts of 1..5 bytes
    for (int nb = 1; nb <= 5; nb++) begin
      send_frame(CM, link_of(4), nb, 32'd405, 0);
      check_dec("R7 runt drop", 5'b10101);
      check_cnt("R7 counters unchanged");
    end

    // R3 duplicate link: lowest index decides
    cfg_write(10, 1, link_of(3), 32'd0, 32'd50);
    send_frame(CM, link_of(3), 6, 32'd310, 0);
    check_dec("R3 lower entry window pass", 5'b11010);
    send_frame(CM, link_of(3), 6, 32'd20, 0);
    check_dec("R3 higher entry ignored", 5'b10110);
    bump_win();
    check_cnt("R3 window counter");
    cfg_write(3, 0, link_of(3), win_lo(3), win_hi(3));
    send_frame(CM, link_of(3), 6, 32'd20, 0);
    check_dec("R3 next entry after invalidate", 5'b11010);

    // R10 write coinciding with the last address byte
    cc_pend = 1; cc_idx = 4'd5; cc_vld = 0; cc_link = link_of(5);
    cc_lo = win_lo(5); cc_hi = win_hi(5);
    send_frame(CM, link_of(5), 6, 32'd510, 0);
    check_dec("R10 same-edge invalidate unseen", 5'b11010);
    send_frame(CM, link_of(5), 6, 32'd510, 0);
    check_dec("R10 invalidate seen next frame", 5'b10110);
    bump_unk();
    check_cnt("R10 unknown counter");
    cc_pend = 1; cc_idx = 4'd5; cc_vld = 1;
    send_frame(CM, link_of(5), 6, 32'd510, 0);
    check_dec("R10 same-edge install unseen", 5'b10110);
    bump_unk();
    send_frame(CM, link_of(5), 6, 32'd510, 0);
    check_dec("R10 install seen next frame", 5'b11010);
    check_cnt("R10 R8 counters");

    // R8 push unknown counter to saturation and beyond
    for (int j = 0; j < 18; j++) begin
      send_frame(CM, 16'hBEEF, 6, 32'd1, 0);
      bump_unk();
    end
    check_cnt("R8 unknown saturates");

    summary();
  end

endmodule